// File: doc/BRIEF.md
# Memory Interface Configuration Controller

This block holds the control state of a four-bank external memory interface. Each bank has one configuration word that software writes through a simple register port. A status word reports which banks have been configured, whether bank configuration is write-protected, and whether the memory path has been stalled. The write protection is a one-way latch: software sets it once, and after that every bank configuration write is dropped until the next reset.

The stall control prepares the device for power removal. Once it is set, the block masks every new grant that the memory arbiter proposes, for every requester. A transfer that was granted earlier is not affected. The stall can only be cleared by a reset, so battery-backed memory cannot be reached by accident afterwards.

While reset is active, the block forces the external memory pins to safe levels, overriding the bus timing logic. All chip, output and byte-write enables are driven inactive high, address bit 1 is driven high, and the data bus is not driven. The upper address lines carry a copy of the internal memory address bus during reset.

Top module: `memcfg_ctrl`

## Requirements
- R1: Bank n (n = 0..3) has a configuration register at byte offset 4*n. While unlocked, a write there stores reg_wdata[CFG_W-1:0]. A read returns the stored value, zero-extended to 32 bits.
- R2: Status bits 3:0 at offset 0x20 are per-bank written flags (bit n belongs to bank n). A flag sets on the first accepted write to its bank and stays set until reset.
- R3: Writing offset 0x24 with bit 0 = 1 sets the lock, which appears as status bit 4 and stays set until reset. Writing 0 there has no effect.
- R4: While the lock is set, bank writes change neither the stored value nor the written flag.
- R5: Writing offset 0x30 with bit 0 = 1 sets the stall, which appears as status bit 5 and stays set until reset. Writing 0 there has no effect.
- R6: From the cycle after the stall is set, arb_grant_out is all zeros for any arb_grant_in. Before that, arb_grant_out equals arb_grant_in. Only new grant pulses are masked, so transfers already granted run on.
- R7: A write to any other offset, including offsets not aligned to 4, is ignored. Reads of such offsets, of 0x24 and of 0x30 return zero. Status bits 31:6 read zero, and reg_rdata is zero when reg_rd is low.
- R8: While rst is high, the outputs are forced: mem_ce_n = 4'hF, mem_oe_n = 2'b11, mem_wb_n = 2'b11, mem_addr1 = 1, mem_data_oe = 0 (data bus high-impedance), and mem_addr_hi = int_addr_hi. While rst is low, each of these outputs follows its tg_* input.
- R9: After reset, every bank register holds CFG_RST, and the written flags, lock and stall are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, same cycle as reg_rd |
| arb_grant_in | input | NREQ | Grants proposed by the arbiter |
| arb_grant_out | output | NREQ | Grants after stall gating |
| int_addr_hi | input | HI_W | Internal memory address bus, upper bits |
| tg_addr_hi | input | HI_W | Upper address from the bus timing logic |
| tg_addr1 | input | 1 | Address bit 1 from the bus timing logic |
| tg_ce_n | input | 4 | Chip enables from the bus timing logic |
| tg_oe_n | input | 2 | Output enables from the bus timing logic |
| tg_wb_n | input | 2 | Byte write enables from the bus timing logic |
| tg_data_oe | input | 1 | Data bus drive enable from the bus timing logic |
| mem_addr_hi | output | HI_W | External upper address |
| mem_addr1 | output | 1 | External address bit 1 |
| mem_ce_n | output | 4 | External chip enables, active low |
| mem_oe_n | output | 2 | External output enables, active low |
| mem_wb_n | output | 2 | External byte write enables, active low |
| mem_data_oe | output | 1 | External data bus drive enable |

## Verification
The assertions are checked on every clock cycle. They cover the sticky behaviour of the lock, the stall and the written flags. They also cover grant masking once a stall write has landed, the freezing of bank state under the lock, zero reads from write-only registers and from the reserved status bits, and the safe pin levels whenever reset is high.

Some behaviour only the bench's scenarios can show: that the right bank takes the right value, that the first accepted write sets exactly one flag, that writing zero to the lock or stall does nothing, that unaligned or unmapped writes alias nothing, and that a second reset clears state that was sticky before.

// File: rtl/memcfg_pkg.sv
package memcfg_pkg;

    localparam int NBANK  = 4;
    localparam int BANK_W = $clog2(NBANK);

    localparam logic [31:0] OFS_STATUS = 32'h20;
    localparam logic [31:0] OFS_LOCK   = 32'h24;
    localparam logic [31:0] OFS_STALL  = 32'h30;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_BANK,
        SEL_STATUS,
        SEL_LOCK,
        SEL_STALL
    } sel_e;

    typedef struct packed {
        sel_e              sel;
        logic [BANK_W-1:0] bank;
    } dec_t;

    typedef struct packed {
        logic [3:0] ce_n;
        logic [1:0] oe_n;
        logic [1:0] wb_n;
        logic       addr1;
        logic       data_oe;
    } pin_t;

    localparam pin_t PIN_SAFE = '{ce_n: 4'hF, oe_n: 2'b11, wb_n: 2'b11,
                                  addr1: 1'b1, data_oe: 1'b0};

    // Map a byte offset to a register select; misaligned offsets map nowhere.
    function automatic dec_t decode_addr(input logic [31:0] a);
        dec_t d;
        d.sel  = SEL_NONE;
        d.bank = '0;
        if (a[1:0] == 2'b00 && a < 32'(NBANK * 4)) begin
            d.sel  = SEL_BANK;
            d.bank = a[BANK_W+1:2];
        end else if (a == OFS_STATUS) begin
            d.sel = SEL_STATUS;
        end else if (a == OFS_LOCK) begin
            d.sel = SEL_LOCK;
        end else if (a == OFS_STALL) begin
            d.sel = SEL_STALL;
        end
        return d;
    endfunction

    function automatic logic [31:0] status_word(input logic [NBANK-1:0] written,
                                                input logic lock,
                                                input logic stall);
        return {{(32-NBANK-2){1'b0}}, stall, lock, written};
    endfunction

endpackage

// File: rtl/memcfg_bank_regs.sv
module memcfg_bank_regs
    import memcfg_pkg::*;
#(
    parameter int              CFG_W   = 16,
    parameter logic [CFG_W-1:0] CFG_RST = '0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [BANK_W-1:0]      wr_bank,
    input  logic [CFG_W-1:0]       wr_data,
    input  logic                   locked,
    output logic [NBANK*CFG_W-1:0] cfg_flat,
    output logic [NBANK-1:0]       written
);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [CFG_W-1:0] cfg_q;
        logic             wr_q;
        logic             hit;

        assign hit = wr_en && !locked && (wr_bank == BANK_W'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q <= CFG_RST;
                wr_q  <= 1'b0;
            end else if (hit) begin
                cfg_q <= wr_data;
                wr_q  <= 1'b1;
            end
        end

        assign cfg_flat[b*CFG_W +: CFG_W] = cfg_q;
        assign written[b]                 = wr_q;
    end

endmodule

// File: rtl/memcfg_sticky_ctl.sv
module memcfg_sticky_ctl (
    input  logic clk,
    input  logic rst,
    input  logic lock_set,
    input  logic stall_set,
    output logic lock_q,
    output logic stall_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q  <= 1'b0;
            stall_q <= 1'b0;
        end else begin
            if (lock_set)  lock_q  <= 1'b1;
            if (stall_set) stall_q <= 1'b1;
        end
    end

endmodule

// File: rtl/memcfg_pin_guard.sv
module memcfg_pin_guard
    import memcfg_pkg::*;
#(
    parameter int HI_W = 18
) (
    input  logic            rst,
    input  logic [HI_W-1:0] int_addr_hi,
    input  logic [HI_W-1:0] tg_addr_hi,
    input  pin_t            tg_pins,
    output logic [HI_W-1:0] mem_addr_hi,
    output pin_t            mem_pins
);

    always_comb begin
        if (rst) begin
            mem_pins    = PIN_SAFE;
            mem_addr_hi = int_addr_hi;
        end else begin
            mem_pins    = tg_pins;
            mem_addr_hi = tg_addr_hi;
        end
    end

endmodule

// File: rtl/memcfg_ctrl.sv
module memcfg_ctrl
    import memcfg_pkg::*;
#(
    parameter int               AW      = 8,
    parameter int               CFG_W   = 16,
    parameter logic [CFG_W-1:0] CFG_RST = 16'h0F0F,
    parameter int               NREQ    = 4,
    parameter int               HI_W    = 18
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [AW-1:0]   reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    input  logic [NREQ-1:0] arb_grant_in,
    output logic [NREQ-1:0] arb_grant_out,
    input  logic [HI_W-1:0] int_addr_hi,
    input  logic [HI_W-1:0] tg_addr_hi,
    input  logic            tg_addr1,
    input  logic [3:0]      tg_ce_n,
    input  logic [1:0]      tg_oe_n,
    input  logic [1:0]      tg_wb_n,
    input  logic            tg_data_oe,
    output logic [HI_W-1:0] mem_addr_hi,
    output logic            mem_addr1,
    output logic [3:0]      mem_ce_n,
    output logic [1:0]      mem_oe_n,
    output logic [1:0]      mem_wb_n,
    output logic            mem_data_oe
);

    dec_t                   dec;
    logic [NBANK*CFG_W-1:0] cfg_flat;
    logic [NBANK-1:0]       written;
    logic                   lock_q;
    logic                   stall_q;
    pin_t                   tg_pins;
    pin_t                   mem_pins;

    assign dec = decode_addr(32'(reg_addr));

    memcfg_bank_regs #(
        .CFG_W   (CFG_W),
        .CFG_RST (CFG_RST)
    ) bank_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr && dec.sel == SEL_BANK),
        .wr_bank  (dec.bank),
        .wr_data  (reg_wdata[CFG_W-1:0]),
        .locked   (lock_q),
        .cfg_flat (cfg_flat),
        .written  (written)
    );

    memcfg_sticky_ctl sticky_i (
        .clk       (clk),
        .rst       (rst),
        .lock_set  (reg_wr && dec.sel == SEL_LOCK  && reg_wdata[0]),
        .stall_set (reg_wr && dec.sel == SEL_STALL && reg_wdata[0]),
        .lock_q    (lock_q),
        .stall_q   (stall_q)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            unique case (dec.sel)
                SEL_BANK:   reg_rdata = 32'(cfg_flat[dec.bank*CFG_W +: CFG_W]);
                SEL_STATUS: reg_rdata = status_word(written, lock_q, stall_q);
                default:    reg_rdata = '0;
            endcase
        end
    end

    // New grants are masked once stalled; in-flight transfers are untouched.
    assign arb_grant_out = stall_q ? '0 : arb_grant_in;

    assign tg_pins = '{ce_n: tg_ce_n, oe_n: tg_oe_n, wb_n: tg_wb_n,
                       addr1: tg_addr1, data_oe: tg_data_oe};

    memcfg_pin_guard #(
        .HI_W (HI_W)
    ) guard_i (
        .rst         (rst),
        .int_addr_hi (int_addr_hi),
        .tg_addr_hi  (tg_addr_hi),
        .tg_pins     (tg_pins),
        .mem_addr_hi (mem_addr_hi),
        .mem_pins    (mem_pins)
    );

    assign mem_ce_n    = mem_pins.ce_n;
    assign mem_oe_n    = mem_pins.oe_n;
    assign mem_wb_n    = mem_pins.wb_n;
    assign mem_addr1   = mem_pins.addr1;
    assign mem_data_oe = mem_pins.data_oe;

endmodule

// File: rtl/memcfg_ctrl_chk.sv
module memcfg_ctrl_chk
    import memcfg_pkg::*;
#(
    parameter int AW    = 8,
    parameter int CFG_W = 16,
    parameter int NREQ  = 4,
    parameter int HI_W  = 18
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   reg_wr,
    input logic                   reg_rd,
    input logic [AW-1:0]          reg_addr,
    input logic [31:0]            reg_wdata,
    input logic [31:0]            reg_rdata,
    input logic [NREQ-1:0]        arb_grant_out,
    input logic                   lock_q,
    input logic                   stall_q,
    input logic [NBANK-1:0]       written,
    input logic [NBANK*CFG_W-1:0] cfg_flat,
    input logic [HI_W-1:0]        int_addr_hi,
    input logic [HI_W-1:0]        mem_addr_hi,
    input logic                   mem_addr1,
    input logic [3:0]             mem_ce_n,
    input logic [1:0]             mem_oe_n,
    input logic [1:0]             mem_wb_n,
    input logic                   mem_data_oe
);

    logic [31:0] a32;
    assign a32 = 32'(reg_addr);

    // R5
    stall_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        stall_q |=> stall_q);

    // R3
    lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> lock_q);

    // R2
    written_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (written != '0) |=> ((written & $past(written)) == $past(written)));

    // R6
    stall_blocks_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && a32 == OFS_STALL && reg_wdata[0]) |=> (arb_grant_out == '0));

    // R4
    locked_write_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (lock_q && reg_wr) |=> ($stable(cfg_flat) && $stable(written)));

    // R7
    status_reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && a32 == OFS_STATUS) |-> (reg_rdata[31:6] == '0));

    // R7
    write_only_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && (a32 == OFS_LOCK || a32 == OFS_STALL)) |-> (reg_rdata == '0));

    // R8
    reset_pins_safe_chk: assert property (@(posedge clk)
        rst |-> (mem_ce_n == 4'hF && mem_oe_n == 2'b11 && mem_wb_n == 2'b11 &&
                 mem_addr1 && !mem_data_oe && mem_addr_hi == int_addr_hi));

endmodule

bind memcfg_ctrl memcfg_ctrl_chk #(
    .AW    (AW),
    .CFG_W (CFG_W),
    .NREQ  (NREQ),
    .HI_W  (HI_W)
) chk_i (
    .clk           (clk),
    .rst           (rst),
    .reg_wr        (reg_wr),
    .reg_rd        (reg_rd),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .arb_grant_out (arb_grant_out),
    .lock_q        (lock_q),
    .stall_q       (stall_q),
    .written       (written),
    .cfg_flat      (cfg_flat),
    .int_addr_hi   (int_addr_hi),
    .mem_addr_hi   (mem_addr_hi),
    .mem_addr1     (mem_addr1),
    .mem_ce_n      (mem_ce_n),
    .mem_oe_n      (mem_oe_n),
    .mem_wb_n      (mem_wb_n),
    .mem_data_oe   (mem_data_oe)
);

// File: tb/memcfg_ctrl_tb_top.sv
module memcfg_ctrl_tb_top;

    localparam int          AW      = 8;
    localparam int          CFG_W   = 16;
    localparam logic [15:0] CFG_RST = 16'h0F0F;
    localparam int          NREQ    = 4;
    localparam int          HI_W    = 18;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            reg_wr = 1'b0;
    logic            reg_rd = 1'b0;
    logic [AW-1:0]   reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [NREQ-1:0] arb_grant_in = '0;
    logic [NREQ-1:0] arb_grant_out;
    logic [HI_W-1:0] int_addr_hi = '0;
    logic [HI_W-1:0] tg_addr_hi = '0;
    logic            tg_addr1 = 1'b0;
    logic [3:0]      tg_ce_n = '0;
    logic [1:0]      tg_oe_n = '0;
    logic [1:0]      tg_wb_n = '0;
    logic            tg_data_oe = 1'b1;
    logic [HI_W-1:0] mem_addr_hi;
    logic            mem_addr1;
    logic [3:0]      mem_ce_n;
    logic [1:0]      mem_oe_n;
    logic [1:0]      mem_wb_n;
    logic            mem_data_oe;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    logic [15:0] exp_cfg [4];
    logic [3:0]  exp_wr;
    logic        exp_lock;
    logic        exp_stall;

    always #5 clk = ~clk;

    memcfg_ctrl #(
        .AW (AW), .CFG_W (CFG_W), .CFG_RST (CFG_RST), .NREQ (NREQ), .HI_W (HI_W)
    ) dut_i (
        .clk (clk), .rst (rst), .reg_wr (reg_wr), .reg_rd (reg_rd),
        .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .arb_grant_in (arb_grant_in), .arb_grant_out (arb_grant_out),
        .int_addr_hi (int_addr_hi), .tg_addr_hi (tg_addr_hi), .tg_addr1 (tg_addr1),
        .tg_ce_n (tg_ce_n), .tg_oe_n (tg_oe_n), .tg_wb_n (tg_wb_n),
        .tg_data_oe (tg_data_oe), .mem_addr_hi (mem_addr_hi), .mem_addr1 (mem_addr1),
        .mem_ce_n (mem_ce_n), .mem_oe_n (mem_oe_n), .mem_wb_n (mem_wb_n),
        .mem_data_oe (mem_data_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int b = 0; b < 4; b++) exp_cfg[b] = CFG_RST;
        exp_wr    = '0;
        exp_lock  = 1'b0;
        exp_stall = 1'b0;
    endtask

    function automatic logic [31:0] exp_read(input int a);
        if (a < 16 && a % 4 == 0) return {16'h0, exp_cfg[a / 4]};
        if (a == 'h20) return {26'h0, exp_stall, exp_lock, exp_wr};
        return 32'h0;
    endfunction

    // Write one register and mirror its effect in the model.
    task automatic mwr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = AW'(a);
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a < 16 && a % 4 == 0 && !exp_lock) begin
            exp_cfg[a / 4] = d[15:0];
            exp_wr[a / 4]  = 1'b1;
        end
        if (a == 'h24 && d[0]) exp_lock  = 1'b1;
        if (a == 'h30 && d[0]) exp_stall = 1'b1;
    endtask

    task automatic rd_chk(input int a, input string req);
        reg_rd   = 1'b1;
        reg_addr = AW'(a);
        #1;
        check(req, reg_rdata, exp_read(a));
        reg_rd = 1'b0;
        #1;
    endtask

    // Every byte offset, aligned or not, against the model.
    task automatic sweep_reads(input string req);
        for (int a = 0; a < 256; a++) rd_chk(a, req);
    endtask

    task automatic grant_sweep(input string req);
        for (int g = 0; g < 16; g++) begin
            arb_grant_in = 4'(g);
            #1;
            check(req, 32'(arb_grant_out), exp_stall ? 32'h0 : 32'(g));
        end
        arb_grant_in = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        model_reset();
        // R8: reset overrides driven-active timing inputs
        repeat (2) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            int_addr_hi = HI_W'(32'h1_2345 * (k + 1));
            tg_addr_hi  = ~int_addr_hi;
            #1;
            check("R8 addr_hi", 32'(mem_addr_hi), 32'(int_addr_hi));
            check("R8 enables", {mem_ce_n, mem_oe_n, mem_wb_n}, 32'hFF);
            check("R8 addr1/data", {mem_addr1, mem_data_oe}, 32'b10);
            #3;
        end
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R9: reset state of every register offset
        sweep_reads("R9 reset state");
        grant_sweep("R6 pass before stall");

        // R8: outside reset, pins follow the timing inputs
        for (int k = 0; k < 4; k++) begin
            tg_ce_n = 4'(k * 5); tg_oe_n = 2'(k); tg_wb_n = 2'(3 - k);
            tg_addr1 = k[0]; tg_data_oe = k[1]; tg_addr_hi = HI_W'(k * 777);
            #1;
            check("R8 pass enables", {mem_ce_n, mem_oe_n, mem_wb_n},
                  {tg_ce_n, tg_oe_n, tg_wb_n});
            check("R8 pass addr", {mem_addr1, mem_data_oe, 14'h0, mem_addr_hi},
                  {tg_addr1, tg_data_oe, 14'h0, tg_addr_hi});
        end

        // R1, R2: partial bank writes, then the rest
        mwr('h00, 32'hFFFF_ABCD);
        mwr('h08, 32'h0000_1234);
        rd_chk('h20, "R2 partial flags");
        sweep_reads("R1 partial banks");
        mwr('h00, 32'h5555_0001);
        rd_chk('h00, "R1 rewrite bank0");

        // R7: unmapped and misaligned writes alias nothing
        mwr('h01, 32'hFFFF_FFFF);
        mwr('h06, 32'hFFFF_FFFF);
        mwr('h10, 32'hFFFF_FFFF);
        mwr('h20, 32'hFFFF_FFFF);
        mwr('h28, 32'hFFFF_FFFF);
        mwr('h34, 32'hFFFF_FFFF);
        mwr('h80, 32'hFFFF_FFFF);
        mwr('hFC, 32'hFFFF_FFFF);
        sweep_reads("R7 unmapped writes");
        reg_addr = 8'h20;
        #1;
        check("R7 rdata idle", reg_rdata, 32'h0);

        // R3: writing zero to the lock does nothing
        mwr('h24, 32'hFFFF_FFFE);
        rd_chk('h20, "R3 lock zero ignored");
        mwr('h04, 32'h0000_BEEF);
        rd_chk('h04, "R1 bank1 unlocked");

        // R3, R4: lock, then writes rejected (bank3 never written)
        mwr('h24, 32'h1);
        rd_chk('h20, "R3 lock set");
        mwr('h0C, 32'h0000_7777);
        mwr('h00, 32'h0000_9999);
        mwr('h24, 32'h0);
        sweep_reads("R4 locked writes");

        // R5, R6: stall zero ignored, then set, then sticky
        mwr('h30, 32'h0);
        rd_chk('h20, "R5 stall zero ignored");
        grant_sweep("R6 still passing");
        mwr('h30, 32'h1);
        rd_chk('h20, "R5 stall set");
        grant_sweep("R6 stalled");
        mwr('h30, 32'h0);
        repeat (3) @(negedge clk);
        rd_chk('h20, "R5 stall sticky");
        grant_sweep("R6 stall sticky");

        // R9: a second reset clears the sticky state
        do_reset();
        #1;
        sweep_reads("R9 second reset");
        grant_sweep("R6 after reset");
        mwr('h0C, 32'h0000_4242);
        rd_chk('h20, "R2 single flag");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule